// File: doc/BRIEF.md
# Secondary Interrupt Combiner with Direct Routing

This block gathers 32 level-sensitive interrupt lines and drives 32 request lines toward a primary interrupt controller. Every input that is both active and enabled contributes to one combined request, which appears on upstream line 31. A group of inputs, lines 21 to 30, can also be sent one by one to the matching upstream lines. Each of these has its own direct-route enable bit. This lets a primary controller treat those sources as separate vectors.

Software reaches the block through a word-indexed register port. The port has a read strobe, a write strobe, a 10-bit word index and 32-bit write data. Read data comes back one cycle after the strobe. Enable bits are changed only through separate set and clear addresses, so software never needs a read-modify-write. A software interrupt flag is merged into bit 0 of the raw level, so firmware can raise line 0 by itself.

The block holds no state machine. Its state is four registers: the sampled input level, the enable mask, the direct-route enable and the software flag. There is no sequencing between them. Set and clear writes change this state, and the upstream lines are registered functions of it.

Top module: `irq_combiner_sic`

## Requirements
- R1: After reset, all 32 upstream lines are low, and reads of word indices 0, 1, 2, 4 and 8 return 0.
- R2: Word index 1 reads the raw level. This is the input level registered on each clock, with the software flag ORed into bit 0.
- R3: A write to index 2 ORs the write data into the enable mask. A write to index 3 clears each mask bit whose data bit is 1. A read of index 2 returns the mask.
- R4: Word index 0 reads the raw level ANDed with the enable mask.
- R5: Upstream line 31 is high exactly when the raw level ANDed with the enable mask is nonzero.
- R6: A write to index 8 ORs the write data, masked to bits 21..30 (0x7FE00000), into the direct-route enable. A write to index 9 clears each route bit whose data bit is 1. A read of index 8 returns the route enable.
- R7: For each line from 21 to 30, the upstream line follows the raw level while its route bit is set, and is low while the bit is clear. Upstream lines 0 to 20 are always low.
- R8: A write of any nonzero value to index 4 sets the software flag. A nonzero write to index 5 clears it. A write of zero to either index changes nothing. A read of index 4 returns raw level bit 0 in bit 0, with the other bits 0.
- R9: Reads of any index other than 0, 1, 2, 4 and 8 return 0. Writes to any index other than 2, 3, 4, 5, 8 and 9 change no state.
- R10: Read data is valid in the cycle after the read strobe and is 0 in a cycle that follows no read. A register write or an input change reaches the upstream lines one cycle after the clock edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 32 | Level-sensitive interrupt sources |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_idx | input | 10 | Word index of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| up_irq | output | 32 | Request lines toward the primary controller |

## Verification
The hardest case to reach is a direct-routed line that is enabled for routing but masked in the enable register. Its source must still appear on its own upstream line while line 31 stays low. The stimulus clears the whole mask first, then sets every route bit with an all-ones write, then drives every input high. This shows that only bits 21 to 30 reach the outputs. A later single-bit route clear then shows that a line can be removed from the routed group one at a time. Write-to-output latency is measured by sampling line 31 in the cycle right after an enable write and again one cycle later.

// File: rtl/sic_pkg.sv
package sic_pkg;
    localparam int LINES  = 32;
    localparam int IDX_W  = 10;

    typedef enum logic [IDX_W-1:0] {
        IDX_MSTAT   = 10'd0,
        IDX_RAW     = 10'd1,
        IDX_ENSET   = 10'd2,
        IDX_ENCLR   = 10'd3,
        IDX_SWSET   = 10'd4,
        IDX_SWCLR   = 10'd5,
        IDX_RTSET   = 10'd8,
        IDX_RTCLR   = 10'd9
    } reg_idx_e;

    function automatic logic [LINES-1:0] range_mask(input int lo, input int hi);
        logic [LINES-1:0] m;
        m = '0;
        for (int i = 0; i < LINES; i++) begin
            if (i >= lo && i <= hi) m[i] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/sic_regs.sv
module sic_regs
    import sic_pkg::*;
#(
    parameter int RT_LO = 21,
    parameter int RT_HI = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_rd,
    input  logic             reg_wr,
    input  logic [IDX_W-1:0] reg_idx,
    input  logic [LINES-1:0] reg_wdata,
    input  logic [LINES-1:0] raw_level,
    output logic [LINES-1:0] en_mask,
    output logic [LINES-1:0] rt_en,
    output logic             sw_flag,
    output logic [LINES-1:0] reg_rdata
);
    localparam logic [LINES-1:0] RT_MASK = range_mask(RT_LO, RT_HI);

    logic [LINES-1:0] rd_mux;
    logic             idx_readable;

    always_comb begin
        rd_mux       = '0;
        idx_readable = 1'b1;
        case (reg_idx)
            IDX_MSTAT: rd_mux = raw_level & en_mask;
            IDX_RAW:   rd_mux = raw_level;
            IDX_ENSET: rd_mux = en_mask;
            IDX_SWSET: rd_mux = {{(LINES-1){1'b0}}, raw_level[0]};
            IDX_RTSET: rd_mux = rt_en;
            default:   idx_readable = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_mask   <= '0;
            rt_en     <= '0;
            sw_flag   <= 1'b0;
            reg_rdata <= '0;
        end else begin
            reg_rdata <= reg_rd ? rd_mux : '0;
            if (reg_wr) begin
                case (reg_idx)
                    IDX_ENSET: en_mask <= en_mask | reg_wdata;
                    IDX_ENCLR: en_mask <= en_mask & ~reg_wdata;
                    IDX_SWSET: if (|reg_wdata) sw_flag <= 1'b1;
                    IDX_SWCLR: if (|reg_wdata) sw_flag <= 1'b0;
                    IDX_RTSET: rt_en <= rt_en | (reg_wdata & RT_MASK);
                    IDX_RTCLR: rt_en <= rt_en & ~reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    // R6: route enable never holds a bit outside the routed group
    a_r6_route_range: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_en & ~RT_MASK) == '0);

    // R3: set write leaves every written bit enabled
    a_r3_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_idx == IDX_ENSET) |=> ((en_mask & $past(reg_wdata)) == $past(reg_wdata)));

    // R3: clear write leaves no written bit enabled
    a_r3_enable_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_idx == IDX_ENCLR) |=> ((en_mask & $past(reg_wdata)) == '0));

    // R9: unmapped read returns zero
    a_r9_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !idx_readable) |=> (reg_rdata == '0));

    // R10: no read strobe, no read data
    a_r10_idle_rdata: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> (reg_rdata == '0));
endmodule

// File: rtl/sic_route.sv
module sic_route
    import sic_pkg::*;
#(
    parameter int RT_LO     = 21,
    parameter int RT_HI     = 30,
    parameter int COMB_LINE = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_level,
    input  logic [LINES-1:0] en_mask,
    input  logic [LINES-1:0] rt_en,
    output logic [LINES-1:0] up_irq
);
    localparam logic [LINES-1:0] RT_MASK   = range_mask(RT_LO, RT_HI);
    localparam logic [LINES-1:0] COMB_BIT  = range_mask(COMB_LINE, COMB_LINE);
    localparam logic [LINES-1:0] QUIET     = ~(RT_MASK | COMB_BIT);

    logic [LINES-1:0] up_next;
    logic             combined;

    assign combined = |(raw_level & en_mask);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        if (g == COMB_LINE) begin : g_comb
            assign up_next[g] = combined;
        end else if (g >= RT_LO && g <= RT_HI) begin : g_route
            assign up_next[g] = rt_en[g] & raw_level[g];
        end else begin : g_quiet
            assign up_next[g] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) up_irq <= '0;
        else        up_irq <= up_next;
    end

    // R5: combined line reflects last cycle's enabled activity
    a_r5_combined: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (up_irq[COMB_LINE] == $past(|(raw_level & en_mask))));

    // R7: routed lines follow the raw level under their route bit
    a_r7_route_follow: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((up_irq & RT_MASK) == $past(raw_level & rt_en & RT_MASK)));

    // R7: lines outside the routed group and the combined line stay low
    a_r7_quiet_lines: assert property (@(posedge clk) disable iff (!rst_n)
        (up_irq & QUIET) == '0);
endmodule

// File: rtl/irq_combiner_sic.sv
module irq_combiner_sic
    import sic_pkg::*;
#(
    parameter int RT_LO     = 21,
    parameter int RT_HI     = 30,
    parameter int COMB_LINE = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      irq_in,
    input  logic             reg_rd,
    input  logic             reg_wr,
    input  logic [9:0]       reg_idx,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic [31:0]      up_irq
);
    logic [LINES-1:0] level_q;
    logic [LINES-1:0] raw_level;
    logic [LINES-1:0] en_mask;
    logic [LINES-1:0] rt_en;
    logic             sw_flag;

    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= '0;
        else        level_q <= irq_in;
    end

    assign raw_level = level_q | {{(LINES-1){1'b0}}, sw_flag};

    sic_regs #(.RT_LO(RT_LO), .RT_HI(RT_HI)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_idx   (reg_idx),
        .reg_wdata (reg_wdata),
        .raw_level (raw_level),
        .en_mask   (en_mask),
        .rt_en     (rt_en),
        .sw_flag   (sw_flag),
        .reg_rdata (reg_rdata)
    );

    sic_route #(.RT_LO(RT_LO), .RT_HI(RT_HI), .COMB_LINE(COMB_LINE)) route_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .raw_level (raw_level),
        .en_mask   (en_mask),
        .rt_en     (rt_en),
        .up_irq    (up_irq)
    );

    // R2: raw level tracks the input sampled one edge earlier
    a_r2_raw_sample: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw_level & ~32'h1) == ($past(irq_in) & ~32'h1)));

    // R8: software flag only changes on a nonzero set/clear write
    a_r8_sw_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && (reg_idx == IDX_SWSET || reg_idx == IDX_SWCLR) && |reg_wdata)
        |=> $stable(sw_flag));
endmodule

// File: tb/irq_combiner_sic_tb_top.sv
module irq_combiner_sic_tb_top;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [9:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] up_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    irq_combiner_sic dut_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .up_irq(up_irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%08h expected=%08h", req, what, act, exp);
        end
    endtask

    task automatic rd(input logic [9:0] idx, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_idx = idx;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [9:0] idx, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = idx; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1", "up_irq after reset", up_irq, 32'h0);
        rd(10'd0, d); chk("R1", "idx0", d, 32'h0);
        rd(10'd1, d); chk("R1", "idx1", d, 32'h0);
        rd(10'd2, d); chk("R1", "idx2", d, 32'h0);
        rd(10'd4, d); chk("R1", "idx4", d, 32'h0);
        rd(10'd8, d); chk("R1", "idx8", d, 32'h0);
    endtask

    task automatic t_raw_and_mask();
        logic [31:0] d;
        irq_in = 32'hA5A5_00F0; settle();
        rd(10'd1, d); chk("R2", "raw level", d, 32'hA5A5_00F0);
        rd(10'd0, d); chk("R4", "masked with empty mask", d, 32'h0);
        chk("R5", "line 31 with empty mask", {31'h0, up_irq[31]}, 32'h0);
        wr(10'd2, 32'h0000_00F0);
        wr(10'd2, 32'h0F00_0000);
        rd(10'd2, d); chk("R3", "mask after two sets", d, 32'h0F00_00F0);
        rd(10'd0, d); chk("R4", "masked status", d, 32'h0500_00F0);
        wr(10'd3, 32'h0000_0030);
        rd(10'd2, d); chk("R3", "mask after clear", d, 32'h0F00_00C0);
        rd(10'd0, d); chk("R4", "masked status after clear", d, 32'h0500_00C0);
        chk("R5", "line 31 active", {31'h0, up_irq[31]}, 32'h1);
        irq_in = 32'h0000_0030; settle();
        chk("R5", "line 31 with only masked inputs", {31'h0, up_irq[31]}, 32'h0);
        irq_in = 32'h0;
        wr(10'd3, 32'hFFFF_FFFF); settle();
    endtask

    task automatic t_timing();
        irq_in = 32'h0000_0005; settle();
        @(negedge clk);
        reg_rd = 1'b1; reg_idx = 10'd1;
        chk("R10", "rdata before read edge", reg_rdata, 32'h0);
        @(negedge clk);
        reg_rd = 1'b0;
        chk("R10", "rdata cycle after strobe", reg_rdata, 32'h0000_0005);
        @(negedge clk);
        chk("R10", "rdata after idle cycle", reg_rdata, 32'h0);
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = 10'd2; reg_wdata = 32'h4;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
        chk("R10", "line 31 same cycle as write edge", {31'h0, up_irq[31]}, 32'h0);
        @(negedge clk);
        chk("R10", "line 31 one cycle later", {31'h0, up_irq[31]}, 32'h1);
        irq_in = 32'h0;
        wr(10'd3, 32'hFFFF_FFFF); settle();
    endtask

    task automatic t_route();
        logic [31:0] d;
        wr(10'd8, 32'hFFFF_FFFF);
        rd(10'd8, d); chk("R6", "route enable masked", d, 32'h7FE0_0000);
        irq_in = 32'hFFFF_FFFF; settle();
        chk("R7", "routed lines with empty mask", up_irq, 32'h7FE0_0000);
        wr(10'd9, 32'h0020_0000); settle();
        rd(10'd8, d); chk("R6", "route after clear", d, 32'h7FC0_0000);
        chk("R7", "line 21 removed", up_irq, 32'h7FC0_0000);
        irq_in = 32'h0; settle();
        chk("R7", "routed lines follow low inputs", up_irq, 32'h0);
        irq_in = 32'h001F_FFFF; settle();
        chk("R7", "lines 0..20 stay low", up_irq, 32'h0);
        irq_in = 32'h0;
        wr(10'd9, 32'hFFFF_FFFF); settle();
    endtask

    task automatic t_soft();
        logic [31:0] d;
        wr(10'd4, 32'h0);
        rd(10'd4, d); chk("R8", "zero set write ignored", d, 32'h0);
        wr(10'd4, 32'h5);
        rd(10'd4, d); chk("R8", "soft flag set", d, 32'h1);
        rd(10'd1, d); chk("R8", "raw bit 0 from soft flag", d, 32'h1);
        wr(10'd2, 32'h1); settle();
        chk("R8", "soft flag drives line 31", {31'h0, up_irq[31]}, 32'h1);
        wr(10'd5, 32'h0); settle();
        chk("R8", "zero clear write ignored", {31'h0, up_irq[31]}, 32'h1);
        wr(10'd5, 32'h8000_0000); settle();
        rd(10'd4, d); chk("R8", "soft flag cleared", d, 32'h0);
        chk("R8", "line 31 drops", {31'h0, up_irq[31]}, 32'h0);
        wr(10'd3, 32'hFFFF_FFFF);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        wr(10'd2, 32'h0000_1234);
        wr(10'd8, 32'h0040_0000);
        wr(10'd6, 32'hFFFF_FFFF);
        wr(10'd7, 32'hFFFF_FFFF);
        wr(10'd10, 32'hFFFF_FFFF);
        wr(10'h3FF, 32'hFFFF_FFFF);
        rd(10'd2, d); chk("R9", "mask untouched", d, 32'h0000_1234);
        rd(10'd8, d); chk("R9", "route untouched", d, 32'h0040_0000);
        rd(10'd4, d); chk("R9", "soft flag untouched", d, 32'h0);
        rd(10'd3, d); chk("R9", "read idx3", d, 32'h0);
        rd(10'd6, d); chk("R9", "read idx6", d, 32'h0);
        rd(10'd9, d); chk("R9", "read idx9", d, 32'h0);
        rd(10'h3FF, d); chk("R9", "read idx 0x3FF", d, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_raw_and_mask();
        t_timing();
        t_route();
        t_soft();
        t_unmapped();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule